// File: doc/BRIEF.md
# Minutes-and-Seconds Countdown Timer

This block is a countdown timer that shows the remaining time as MM:SS on four seven-segment digits. The board clock is divided down inside the block into a one-second square wave. The block derives a one-second tick and a half-second tick from that wave, and these ticks pace both the countdown and the adjustment of the time value. The timer powers up, and returns on reset, holding 04:00. A start request begins the countdown and a stop request freezes it.

While the timer is idle, two switches raise the time value. The fast switch adds one second every half second. The slow switch adds one second every second. When the countdown reaches 00:00, the timer halts and ignores start until the value is changed again. During the last ten seconds a status LED blinks at the rate of the divider's square wave.

The digit patterns drive the segments directly. There is no display multiplexing. Inputs are expected to be clean and already synchronous to the clock.

Top module: `countdown_timer`

## Requirements
- R1: A synchronous active-high `rst` loads 04:00 and stops the timer. The segment outputs show 04:00, with the LED off, from the second rising edge after `rst` is released.
- R2: Each digit output is active-low in gfedcba order (bit 6 = g, bit 0 = a). The lit patterns for 0..9 are 3F,06,5B,4F,66,6D,7D,07,7F,6F, each inverted. The outputs are, in order, minutes tens, minutes ones, seconds tens and seconds ones.
- R3: An accepted start restarts the divider. The first decrement lands TICK_DIV clock edges after the start edge, and each later decrement follows TICK_DIV edges after the one before. The segment outputs show each new value one cycle after it is loaded.
- R4: Decrementing a value whose seconds are 00 gives seconds 59 and one minute less (04:00 becomes 03:59).
- R5: A stop while running freezes the value. A later start resumes the countdown from the frozen value.
- R6: When the value reaches 00:00 the timer stops and holds. A start request is ignored while the value is 00:00.
- R7: While the timer is idle, each of the two set switches adds one second, carrying base 60 into the minutes, with 99:59 wrapping to 00:00. The fast switch adds at every half-tick: every TICK_DIV/2 edges counted from the last divider restart. The slow switch adds at every full tick. If both switches are held, only the fast rate applies.
- R8: The set switches have no effect while the timer is running.
- R9: While running with 10 or fewer seconds left, the LED follows the divider square wave: on for the first half of each second and off for the second half. In every other state the LED is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Board clock |
| rst | input | 1 | Synchronous active-high reset; reloads 04:00 and stops the timer |
| start_i | input | 1 | Start or resume the countdown |
| stop_i | input | 1 | Freeze the countdown |
| set_fast_i | input | 1 | Raise the idle value at the half-second rate |
| set_slow_i | input | 1 | Raise the idle value at the one-second rate |
| seg_min_tens_o | output | 7 | Minutes tens digit, active-low gfedcba |
| seg_min_ones_o | output | 7 | Minutes ones digit, active-low gfedcba |
| seg_sec_tens_o | output | 7 | Seconds tens digit, active-low gfedcba |
| seg_sec_ones_o | output | 7 | Seconds ones digit, active-low gfedcba |
| flash_led_o | output | 1 | Blinking status LED for the final ten seconds |

## Verification
The assertions assume that `start_i`, `stop_i` and the set switches are synchronous levels sampled at the rising edge. They also assume that a start and a restart of the divider share one edge, so a half-tick with start high is exempt from the square-wave check. The stimulus changes every input at the falling edge. It pulses start and stop for exactly one cycle, and it adjusts the value only after a reset, so that the divider phase is known and the number of added seconds follows from the hold window alone. Random hold windows, switch choices and run lengths come from a seeded generator, and directed cases cover the borrow, the final-ten-second blink, the halt at zero and the 99:59 wrap.

// File: rtl/ct_pkg.sv
`timescale 1ns/1ps
package ct_pkg;

  localparam int NUM_DIGITS = 4;
  localparam int SEG_W      = 7;

  typedef struct packed {
    logic [3:0] min_t;
    logic [3:0] min_o;
    logic [3:0] sec_t;
    logic [3:0] sec_o;
  } bcd_time_t;

  // one second less, with base-60 borrow from the minutes
  function automatic bcd_time_t bcd_dec(bcd_time_t t);
    bcd_time_t r;
    r = t;
    if (t.sec_o != 4'd0) begin
      r.sec_o = t.sec_o - 4'd1;
    end else begin
      r.sec_o = 4'd9;
      if (t.sec_t != 4'd0) begin
        r.sec_t = t.sec_t - 4'd1;
      end else begin
        r.sec_t = 4'd5;
        if (t.min_o != 4'd0) begin
          r.min_o = t.min_o - 4'd1;
        end else begin
          r.min_o = 4'd9;
          r.min_t = t.min_t - 4'd1;
        end
      end
    end
    return r;
  endfunction

  // one second more, 99:59 wraps to 00:00
  function automatic bcd_time_t bcd_inc(bcd_time_t t);
    bcd_time_t r;
    r = t;
    if (t.sec_o != 4'd9) begin
      r.sec_o = t.sec_o + 4'd1;
    end else begin
      r.sec_o = 4'd0;
      if (t.sec_t != 4'd5) begin
        r.sec_t = t.sec_t + 4'd1;
      end else begin
        r.sec_t = 4'd0;
        if (t.min_o != 4'd9) begin
          r.min_o = t.min_o + 4'd1;
        end else begin
          r.min_o = 4'd0;
          r.min_t = (t.min_t == 4'd9) ? 4'd0 : t.min_t + 4'd1;
        end
      end
    end
    return r;
  endfunction

  function automatic logic bcd_is_zero(bcd_time_t t);
    return (t == '0);
  endfunction

  function automatic logic bcd_is_one(bcd_time_t t);
    return (t.min_t == 4'd0) && (t.min_o == 4'd0) &&
           (t.sec_t == 4'd0) && (t.sec_o == 4'd1);
  endfunction

endpackage

// File: rtl/ct_tick_gen.sv
`timescale 1ns/1ps
module ct_tick_gen #(
  parameter int TICK_DIV = 125_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic half_pulse,
  output logic sec_pulse,
  output logic sec_wave
);

  localparam int HALF = TICK_DIV / 2;
  localparam int CW   = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(TICK_DIV - 1);
  localparam logic [CW-1:0] MID_CNT  = CW'(HALF - 1);
  localparam logic [CW-1:0] HALF_CNT = CW'(HALF);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST_CNT) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // square wave: high over the first half of each second
  assign sec_wave   = (cnt_q < HALF_CNT);
  assign sec_pulse  = (cnt_q == LAST_CNT);
  assign half_pulse = sec_pulse || (cnt_q == MID_CNT);

endmodule

// File: rtl/ct_time_core.sv
`timescale 1ns/1ps
module ct_time_core
  import ct_pkg::*;
#(
  parameter int PRESET_MIN = 4,
  parameter int PRESET_SEC = 0
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start_i,
  input  logic      stop_i,
  input  logic      set_fast_i,
  input  logic      set_slow_i,
  input  logic      half_pulse,
  input  logic      sec_pulse,
  output bcd_time_t time_q,
  output logic      run_q,
  output logic      start_ok
);

  localparam bcd_time_t PRESET = {4'(PRESET_MIN / 10), 4'(PRESET_MIN % 10),
                                  4'(PRESET_SEC / 10), 4'(PRESET_SEC % 10)};

  logic set_step;

  assign start_ok = !run_q && start_i && !bcd_is_zero(time_q);
  assign set_step = set_fast_i ? half_pulse : (set_slow_i && sec_pulse);

  always_ff @(posedge clk) begin
    if (rst) begin
      time_q <= PRESET;
      run_q  <= 1'b0;
    end else if (run_q) begin
      if (stop_i) begin
        run_q <= 1'b0;
      end else if (sec_pulse) begin
        time_q <= bcd_dec(time_q);
        if (bcd_is_one(time_q)) begin
          run_q <= 1'b0;
        end
      end
    end else if (start_ok) begin
      run_q <= 1'b1;
    end else if (set_step) begin
      time_q <= bcd_inc(time_q);
    end
  end

endmodule

// File: rtl/ct_seg_decode.sv
`timescale 1ns/1ps
module ct_seg_decode
  import ct_pkg::*;
(
  input  logic [3:0]       digit_i,
  output logic [SEG_W-1:0] seg_n_o
);

  logic [SEG_W-1:0] lit;

  always_comb begin
    case (digit_i)
      4'd0:    lit = 7'b0111111;
      4'd1:    lit = 7'b0000110;
      4'd2:    lit = 7'b1011011;
      4'd3:    lit = 7'b1001111;
      4'd4:    lit = 7'b1100110;
      4'd5:    lit = 7'b1101101;
      4'd6:    lit = 7'b1111101;
      4'd7:    lit = 7'b0000111;
      4'd8:    lit = 7'b1111111;
      4'd9:    lit = 7'b1101111;
      default: lit = 7'b0000000;
    endcase
  end

  assign seg_n_o = ~lit;

endmodule

// File: rtl/countdown_timer.sv
`timescale 1ns/1ps
module countdown_timer
  import ct_pkg::*;
#(
  parameter int TICK_DIV   = 125_000_000,
  parameter int PRESET_MIN = 4,
  parameter int PRESET_SEC = 0,
  parameter int FLASH_SECS = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       set_fast_i,
  input  logic       set_slow_i,
  output logic [6:0] seg_min_tens_o,
  output logic [6:0] seg_min_ones_o,
  output logic [6:0] seg_sec_tens_o,
  output logic [6:0] seg_sec_ones_o,
  output logic       flash_led_o
);

  localparam logic [6:0] FLASH_LIM = 7'(FLASH_SECS);

  logic      half_pulse, sec_pulse, sec_wave;
  logic      start_ok, run_q;
  bcd_time_t time_q;

  ct_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk        (clk),
    .rst        (rst),
    .restart    (start_ok),
    .half_pulse (half_pulse),
    .sec_pulse  (sec_pulse),
    .sec_wave   (sec_wave)
  );

  ct_time_core #(.PRESET_MIN(PRESET_MIN), .PRESET_SEC(PRESET_SEC)) u_core (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .set_fast_i (set_fast_i),
    .set_slow_i (set_slow_i),
    .half_pulse (half_pulse),
    .sec_pulse  (sec_pulse),
    .time_q     (time_q),
    .run_q      (run_q),
    .start_ok   (start_ok)
  );

  // digit index 0 is the leftmost (minutes tens)
  logic [3:0]       digit_v [NUM_DIGITS];
  logic [SEG_W-1:0] seg_raw [NUM_DIGITS];
  logic [SEG_W-1:0] seg_q   [NUM_DIGITS];

  assign digit_v[0] = time_q.min_t;
  assign digit_v[1] = time_q.min_o;
  assign digit_v[2] = time_q.sec_t;
  assign digit_v[3] = time_q.sec_o;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    ct_seg_decode u_dec (
      .digit_i (digit_v[g]),
      .seg_n_o (seg_raw[g])
    );
    always_ff @(posedge clk) begin
      if (rst) seg_q[g] <= '1;
      else     seg_q[g] <= seg_raw[g];
    end
  end

  assign seg_min_tens_o = seg_q[0];
  assign seg_min_ones_o = seg_q[1];
  assign seg_sec_tens_o = seg_q[2];
  assign seg_sec_ones_o = seg_q[3];

  // final-seconds window: no minutes left and seconds at or under the limit
  logic [6:0] sec_bin;
  logic       in_zone;
  logic       flash_q;

  assign sec_bin = {3'b000, time_q.sec_t} * 7'd10 + {3'b000, time_q.sec_o};
  assign in_zone = (time_q.min_t == 4'd0) && (time_q.min_o == 4'd0) &&
                   (sec_bin <= FLASH_LIM);

  always_ff @(posedge clk) begin
    if (rst) flash_q <= 1'b0;
    else     flash_q <= run_q && in_zone && sec_wave;
  end

  assign flash_led_o = flash_q;

endmodule

// File: rtl/ct_checker.sv
`timescale 1ns/1ps
module ct_checker (
  input logic        clk,
  input logic        rst,
  input logic        start_i,
  input logic        running,
  input logic [15:0] time_bits,
  input logic        sec_pulse,
  input logic        half_pulse,
  input logic        sec_wave,
  input logic        flash_led_o
);

  // R1
  reset_stops_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !running);

  // R3
  time_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (running && !sec_pulse) |=> $stable(time_bits));

  // R6
  zero_not_running_chk: assert property (@(posedge clk) disable iff (rst)
    running |-> (time_bits != 16'd0));

  // R6
  start_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!running && time_bits == 16'd0 && start_i) |=> !running);

  // R7
  bcd_range_chk: assert property (@(posedge clk) disable iff (rst)
    (time_bits[7:4] <= 4'd5) && (time_bits[3:0] <= 4'd9));

  // R9
  led_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !running |=> !flash_led_o);

  // R9
  wave_rise_chk: assert property (@(posedge clk) disable iff (rst)
    sec_pulse |=> sec_wave);

  // R9
  wave_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (half_pulse && !sec_pulse && !start_i) |=> !sec_wave);

endmodule

bind countdown_timer ct_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .running     (run_q),
  .time_bits   (time_q),
  .sec_pulse   (sec_pulse),
  .half_pulse  (half_pulse),
  .sec_wave    (sec_wave),
  .flash_led_o (flash_led_o)
);

// File: tb/tb_countdown_timer.sv
`timescale 1ns/1ps
module tb_countdown_timer;

  localparam int DIV  = 8;
  localparam int HALF = DIV / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, stop_i = 1'b0, set_fast_i = 1'b0, set_slow_i = 1'b0;
  logic [6:0] seg_mt, seg_mo, seg_st, seg_so;
  logic led;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int seed_r;

  always #4 clk = ~clk;

  countdown_timer #(.TICK_DIV(DIV)) dut (
    .clk            (clk),
    .rst            (rst),
    .start_i        (start_i),
    .stop_i         (stop_i),
    .set_fast_i     (set_fast_i),
    .set_slow_i     (set_slow_i),
    .seg_min_tens_o (seg_mt),
    .seg_min_ones_o (seg_mo),
    .seg_sec_tens_o (seg_st),
    .seg_sec_ones_o (seg_so),
    .flash_led_o    (led)
  );

  // active-low gfedcba patterns from R2
  function automatic int seg2dig(logic [6:0] s);
    case (s)
      7'h40: return 0;
      7'h79: return 1;
      7'h24: return 2;
      7'h30: return 3;
      7'h19: return 4;
      7'h12: return 5;
      7'h02: return 6;
      7'h78: return 7;
      7'h00: return 8;
      7'h10: return 9;
      default: return -1;
    endcase
  endfunction

  function automatic int shown_secs();
    int a, b, c, d;
    a = seg2dig(seg_mt); b = seg2dig(seg_mo);
    c = seg2dig(seg_st); d = seg2dig(seg_so);
    if (a < 0 || b < 0 || c < 0 || d < 0) return -1;
    return (a * 10 + b) * 60 + c * 10 + d;
  endfunction

  function automatic int steps_in(int a, int b, int period);
    return (b / period) - (a / period);
  endfunction

  task automatic check_val(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
  endtask

  // samples DIV-1 points inside one second, starting one cycle after its tick
  task automatic led_window(output bit saw1, output bit saw0);
    saw1 = 1'b0; saw0 = 1'b0;
    for (int i = 0; i < DIV - 1; i++) begin
      tick(1);
      if (led) saw1 = 1'b1; else saw0 = 1'b1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit s1, s0;
    seed_r = $urandom(32'd2024);

    // R1 / R2: reset state
    do_reset();
    tick(1);
    check_val("R1 preset after reset", shown_secs(), 240);
    check_val("R1 led off after reset", int'(led), 0);
    check_val("R2 minutes ones pattern for 4", int'(seg_mo), 'h19);
    check_val("R2 seconds tens pattern for 0", int'(seg_st), 'h40);

    // R3 / R4: start, first tick timing and borrow
    pulse_start();
    tick(HALF);
    check_val("R3 no decrement before first tick", shown_secs(), 240);
    tick(DIV);
    check_val("R4 04:00 borrows to 03:59", shown_secs(), 239);
    check_val("R4 seconds tens shows 5", seg2dig(seg_st), 5);
    tick(DIV * 9);
    check_val("R3 ten seconds elapsed", shown_secs(), 230);

    // R8: set switches while running
    set_fast_i = 1'b1; set_slow_i = 1'b1;
    tick(DIV * 3);
    set_fast_i = 1'b0; set_slow_i = 1'b0;
    check_val("R8 set ignored while running", shown_secs(), 227);

    // R5: stop freezes, start resumes
    pulse_stop();
    tick(DIV * 5);
    check_val("R5 value frozen after stop", shown_secs(), 227);
    pulse_start();

    // R9: led window around the final ten seconds
    tick(216 * DIV + 1);
    check_val("R5 resumed countdown reaches 11", shown_secs(), 11);
    led_window(s1, s0);
    check_val("R9 led dark with 11 s left", int'(s1), 0);
    tick(1);
    led_window(s1, s0);
    check_val("R9 led blinks with 10 s left", int'(s1 && s0), 1);
    tick(1);
    check_val("R3 countdown at 9", shown_secs(), 9);

    // R6: halt at zero, start ignored
    tick(9 * DIV + 3);
    check_val("R6 value holds at 00:00", shown_secs(), 0);
    check_val("R9 led off at 00:00", int'(led), 0);
    pulse_start();
    tick(DIV * 3);
    check_val("R6 start ignored at 00:00", shown_secs(), 0);

    // R7: fast adjust from 04:00 wraps through 99:59 to 00:00
    do_reset();
    set_fast_i = 1'b1;
    tick(5760 * HALF);
    set_fast_i = 1'b0;
    tick(2);
    check_val("R7 wrap from 99:59 to 00:00", shown_secs(), 0);

    // R7 / R3 / R5: seeded random adjust, run, stop and resume
    for (int it = 0; it < 10; it++) begin
      int a, b, mode, total, n1, n2, incs, rem;
      a    = int'($urandom_range(0, 20));
      b    = a + int'($urandom_range(1, 120));
      mode = int'($urandom_range(0, 2));
      do_reset();
      tick(a);
      set_fast_i = (mode != 1);
      set_slow_i = (mode != 0);
      tick(b - a);
      set_fast_i = 1'b0; set_slow_i = 1'b0;
      tick(2);
      incs  = (mode == 1) ? steps_in(a, b, DIV) : steps_in(a, b, HALF);
      total = (240 + incs) % 6000;
      check_val("R7 adjusted value", shown_secs(), total);

      n1 = int'($urandom_range(1, 15));
      pulse_start();
      tick(n1 * DIV + HALF);
      rem = (total > n1) ? total - n1 : 0;
      check_val("R3 random run length", shown_secs(), rem);
      pulse_stop();
      tick(DIV * 2);
      check_val("R5 random stop holds", shown_secs(), rem);

      n2 = int'($urandom_range(1, 10));
      pulse_start();
      tick(n2 * DIV + HALF);
      rem = (rem > n2) ? rem - n2 : 0;
      check_val("R5 random resume", shown_secs(), rem);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule